// File: doc/BRIEF.md
# Downward Spread Spectrum Offset Generator

This block drives the frequency-offset input of a fractional-N or numerically controlled clock synthesizer, so that the synthesized clock is smeared downward across a narrow band and its emission peaks are lowered. It runs on the reference clock and produces a signed offset word in parts per million. The word follows a symmetric triangle. It starts at zero, descends linearly to a negative peak, climbs back to zero, and repeats. The offset is never positive, so the synthesized clock never runs above its nominal frequency.

Spreading is requested by holding the active-low select `ss_n` low. The select passes through a small synchronizer and is acted on only when the triangle is at zero. Releasing it therefore lets the current triangle finish, and the output then rests at exactly zero. The spread depth comes from a configuration register. Values above the allowed maximum of 6000 ppm (0.6 %) are clamped. The depth is captured only when a triangle starts. The half-period length is derived from the reference and modulation frequency parameters, so one triangle lasts one modulation period, which is about 31.5 kHz by default.

The offset word is a level that the synthesizer samples every reference cycle. It is not a transaction, so it carries no valid/ready pair, and the control inputs stay plain.

Top module: `ss_downspread_gen`

## Requirements
- R1: While `rst_n` is low the offset is 0. After reset the first non-zero value of every triangle is negative, equal to minus one step, so the ramp always starts downward.
- R2: Spreading is enabled by `ss_n` = 0 and disabled by `ss_n` = 1. The level reaches the generator after SYNC_STAGES (default 2) reference cycles. While disabled and at zero, the offset stays exactly 0.
- R3: The offset word is never greater than 0.
- R4: A depth above MAX_PPM (6000) is treated as MAX_PPM. The offset magnitude never exceeds MAX_PPM.
- R5: The step is floor(clamped depth / HALF). At triangle position k the offset equals -(step x k).
- R6: Each triangle takes HALF cycles from 0 down to -(step x HALF), then HALF cycles back to 0. The position changes by exactly one per cycle.
- R7: Releasing `ss_n` in the middle of a triangle does not cut it short. The triangle completes, and only then does the offset rest at 0.
- R8: The depth is sampled only when a triangle starts. A depth change in the middle of a triangle takes effect at the next triangle.
- R9: HALF = floor(REF_HZ / (2 x MOD_HZ)), so consecutive triangles start 2 x HALF cycles apart (454 with the defaults).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ss_n | input | 1 | Active-low spread select, asynchronous to the generator |
| depth_ppm | input | DEPTH_W | Programmed spread depth in ppm |
| offset_o | output | OFS_W | Signed frequency offset in ppm, 0 or negative |

## Verification
The assertions assume that `depth_ppm` is stable at the reference edge on which a triangle starts, and that HALF is at least 2. They also assume that OFS_W is wide enough to hold -MAX_PPM. The stimulus changes the depth and the select only on the falling clock edge, which keeps every capture clean. It changes the depth both between triangles and in their middle, and it sets it above the clamp limit. The select is released partway down a ramp to exercise the deferred shutdown.

// File: rtl/ss_pkg.sv
package ss_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } ramp_dir_t;

  function automatic int unsigned half_count(input int unsigned ref_hz, input int unsigned mod_hz);
    return ref_hz / (2 * mod_hz);
  endfunction
endpackage

// File: rtl/ss_en_sync.sv
module ss_en_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n_i,
  output logic en_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= 1'b1;
        else        sh_q <= sel_n_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= {sh_q[STAGES-2:0], sel_n_i};
      end
    end
  endgenerate

  assign en_o = ~sh_q[STAGES-1];
endmodule

// File: rtl/ss_tri_phase.sv
module ss_tri_phase
  import ss_pkg::*;
#(
  parameter int HALF  = 227,
  parameter int POS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  output logic [POS_W-1:0] pos_o,
  output logic             load_o
);
  localparam logic [POS_W-1:0] LAST = POS_W'(HALF);
  localparam logic [POS_W-1:0] ONE  = POS_W'(1);

  ramp_dir_t        dir_q;
  logic [POS_W-1:0] pos_q;

  assign load_o = (pos_q == '0) && en_i;
  assign pos_o  = pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      dir_q <= DIR_DOWN;
    end else if (pos_q == '0) begin
      dir_q <= DIR_DOWN;
      if (en_i) pos_q <= ONE;
    end else if (dir_q == DIR_DOWN) begin
      if (pos_q == LAST) begin
        dir_q <= (LAST == ONE) ? DIR_DOWN : DIR_UP;
        pos_q <= pos_q - ONE;
      end else begin
        pos_q <= pos_q + ONE;
      end
    end else begin
      if (pos_q == ONE) dir_q <= DIR_DOWN;
      pos_q <= pos_q - ONE;
    end
  end

  assert_pos_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= LAST);
  assert_no_midcut_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q != '0 && dir_q == DIR_DOWN) |=> (pos_q != '0));
  assert_ramp_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_q == DIR_UP && pos_q != '0) |=> (pos_q == $past(pos_q) - ONE));
  assert_start_down_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q == '0) |=> (dir_q == DIR_DOWN));
endmodule

// File: rtl/ss_depth_step.sv
module ss_depth_step #(
  parameter int DEPTH_W = 16,
  parameter int HALF    = 227,
  parameter int MAX_PPM = 6000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [DEPTH_W-1:0] depth_i,
  output logic [DEPTH_W-1:0] step_o
);
  localparam logic [DEPTH_W-1:0] CAP    = DEPTH_W'(MAX_PPM);
  localparam logic [DEPTH_W-1:0] DIVISOR = DEPTH_W'(HALF);

  logic [DEPTH_W-1:0] clamped;
  logic [DEPTH_W-1:0] step_q;

  assign clamped = (depth_i > CAP) ? CAP : depth_i;
  assign step_o  = step_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      step_q <= '0;
    else if (load_i) step_q <= clamped / DIVISOR;
  end

  assert_step_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(step_q));
  assert_step_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (64'(step_q) * 64'(HALF)) <= 64'(MAX_PPM));
endmodule

// File: rtl/ss_downspread_gen.sv
module ss_downspread_gen
  import ss_pkg::*;
#(
  parameter int REF_HZ      = 14318000,
  parameter int MOD_HZ      = 31500,
  parameter int DEPTH_W     = 16,
  parameter int OFS_W       = 16,
  parameter int MAX_PPM     = 6000,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ss_n,
  input  logic [DEPTH_W-1:0]      depth_ppm,
  output logic signed [OFS_W-1:0] offset_o
);
  localparam int HALF   = int'(half_count(REF_HZ, MOD_HZ));
  localparam int POS_W  = $clog2(HALF + 1);
  localparam int PROD_W = DEPTH_W + POS_W;

  logic               en;
  logic               load;
  logic [POS_W-1:0]   pos;
  logic [DEPTH_W-1:0] step;
  logic [PROD_W-1:0]  mag;
  logic signed [OFS_W-1:0] mag_s;

  ss_en_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sel_n_i(ss_n), .en_o(en)
  );

  ss_tri_phase #(.HALF(HALF), .POS_W(POS_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .en_i(en), .pos_o(pos), .load_o(load)
  );

  ss_depth_step #(.DEPTH_W(DEPTH_W), .HALF(HALF), .MAX_PPM(MAX_PPM)) u_step (
    .clk(clk), .rst_n(rst_n), .load_i(load), .depth_i(depth_ppm), .step_o(step)
  );

  assign mag      = PROD_W'(step) * PROD_W'(pos);
  assign mag_s    = $signed(mag[OFS_W-1:0]);
  assign offset_o = -mag_s;

  assert_nonpos_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (offset_o[OFS_W-1] || offset_o == '0));
  assert_depth_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(offset_o) >= -MAX_PPM);
endmodule

// File: tb/tb_ss_downspread_gen.sv
module tb_ss_downspread_gen;
  localparam int CLK_PERIOD = 10;
  localparam int REF_HZ = 14318000;
  localparam int MOD_HZ = 31500;
  localparam int HALF   = REF_HZ / (2 * MOD_HZ);
  localparam int LIMIT  = 6000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ss_n = 1'b1;
  logic [15:0] depth = 16'd0;
  logic signed [15:0] offset_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int expq[$];

  int m_pos = 0, m_step = 0, s1 = 1, s2 = 1;
  bit m_up = 0;

  ss_downspread_gen dut (
    .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .depth_ppm(depth), .offset_o(offset_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model: pushes the expected offset after each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_pos = 0; m_up = 0; m_step = 0; s1 = 1; s2 = 1;
    end else begin
      if (m_pos == 0) begin
        m_up = 0;
        if (s2 == 0) begin
          m_step = ((int'(depth) > LIMIT) ? LIMIT : int'(depth)) / HALF;
          m_pos = 1;
        end
      end else if (!m_up) begin
        if (m_pos == HALF) begin m_up = 1; m_pos = m_pos - 1; end
        else m_pos = m_pos + 1;
      end else begin
        m_pos = m_pos - 1;
        if (m_pos == 0) m_up = 0;
      end
      s2 = s1;
      s1 = int'(ss_n);
    end
    expq.push_back(-(m_step * m_pos));
  end

  // monitor: compares the design against the model each cycle (R6 profile)
  always @(negedge clk) begin
    cyc++;
    if (expq.size() > 0) begin
      int e;
      e = expq.pop_front();
      total++;
      if (int'(offset_o) != e) begin
        bad++;
        $display("FAIL R6 cycle %0d offset actual=%0d expected=%0d", cyc, offset_o, e);
      end
    end
  end

  task automatic check(input bit ok, input string rq, input int act, input int exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp_v);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_departure(output int at);
    int prev;
    prev = int'(offset_o);
    at = -1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (prev == 0 && int'(offset_o) != 0) begin at = cyc; return; end
      prev = int'(offset_o);
    end
  endtask

  task automatic track_triangle(output int mn, output int mx);
    mn = int'(offset_o);
    mx = int'(offset_o);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (int'(offset_o) < mn) mn = int'(offset_o);
      if (int'(offset_o) > mx) mx = int'(offset_o);
      if (int'(offset_o) == 0) return;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int t0, t1, mn, mx;
    int step6000;
    step6000 = LIMIT / HALF;

    tick(4);
    check(offset_o == 0, "R1 reset offset", int'(offset_o), 0);
    rst_n = 1'b1;
    tick(20);
    check(offset_o == 0, "R2 disabled idle", int'(offset_o), 0);

    depth = 16'd6000;
    ss_n = 1'b0;
    wait_departure(t0);
    check(int'(offset_o) == -step6000, "R1 first step downward", int'(offset_o), -step6000);
    track_triangle(mn, mx);
    check(mn == -step6000 * HALF, "R5 peak depth", mn, -step6000 * HALF);
    check(mx <= 0, "R3 never above nominal", mx, 0);
    wait_departure(t1);
    check(t1 - t0 == 2 * HALF, "R9 modulation period", t1 - t0, 2 * HALF);

    depth = 16'd9000;
    track_triangle(mn, mx);
    check(mn == -step6000 * HALF, "R8 old depth kept", mn, -step6000 * HALF);
    wait_departure(t0);
    depth = 16'd1000;
    track_triangle(mn, mx);
    check(mn == -step6000 * HALF, "R4 clamped depth", mn, -step6000 * HALF);
    check(mn >= -LIMIT, "R4 magnitude bound", mn, -LIMIT);

    wait_departure(t0);
    check(int'(offset_o) == -(1000 / HALF), "R5 new step", int'(offset_o), -(1000 / HALF));
    track_triangle(mn, mx);
    check(mn == -(1000 / HALF) * HALF, "R8 new depth applied", mn, -(1000 / HALF) * HALF);

    wait_departure(t0);
    tick(100);
    ss_n = 1'b1;
    tick(10);
    check(offset_o != 0, "R7 ramp continues after release", int'(offset_o), -1);
    track_triangle(mn, mx);
    check(mn == -(1000 / HALF) * HALF, "R7 triangle completed", mn, -(1000 / HALF) * HALF);
    tick(3 * HALF);
    check(offset_o == 0, "R2 rests at zero", int'(offset_o), 0);
    tick(HALF);
    check(offset_o == 0, "R2 still zero", int'(offset_o), 0);

    tick(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule